// File: doc/BRIEF.md
# Named Split-Phase Barrier Unit

This unit synchronises a fixed group of participants through several independent barriers, each addressed by a small numeric identifier. Reaching a barrier and waiting for it are two separate requests. A participant announces that it has arrived, keeps doing useful work, and only later asks to be held until everyone else has arrived. Because of this split, the time between arriving and needing completion can be filled with unrelated work.

Each barrier keeps one arrival bit per participant and a one-bit phase. The barrier completes when every participant's bit is set. At that point the bits clear and the phase flips. When a participant arrives, the unit records the barrier's phase at that moment. A wait request is satisfied once the barrier's phase differs from the recorded value. A waiter that comes late is therefore released at once, and a wakeup cannot be lost when completion happens before the wait is issued. A participant that arrives twice in the same phase gets an error pulse, and its second arrival is dropped.

Top module: `split_barrier_unit`

## Requirements
- R1: After reset, `release_o` and `err_o` are all low, every barrier is empty and in phase 0. A wait issued before any arrival is held, with no release.
- R2: An arrival from participant p (`sig_valid[p]` with barrier number `sig_id[p*IDW +: IDW]`) is taken in any cycle. It causes no release and no error for p, so the participant never stalls on it.
- R3: A barrier completes on the clock edge where its last missing arrival is sampled. Arrivals sampled on the same edge all count. On completion the arrival bits clear and the phase flips.
- R4: A pending wait by p on barrier b (`wait_valid[p]`, `wait_id[p*IDW +: IDW]`) raises `release_o[p]` for exactly one cycle, in the cycle after the edge that completes b.
- R5: If b has completed since p's last arrival on b, a wait by p on b raises `release_o[p]` in the cycle after the edge that sampled the wait.
- R6: A wait sampled on the same edge as the completing arrival is released in the cycle after that edge.
- R7: After a completion, a participant that arrives again and then waits on the same barrier is held until the new phase completes.
- R8: A second arrival by p on b in the same phase raises `err_o[p]` for one cycle after its edge. That arrival is ignored: the barrier still needs every other participant before it completes.
- R9: Barriers with different numbers do not interact. Arrivals and completions on one barrier never release waiters on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sig_valid | input | N_PART | Per-participant arrival request |
| sig_id | input | N_PART*IDW | Barrier number of each arrival, field p at bits p*IDW +: IDW |
| wait_valid | input | N_PART | Per-participant wait request |
| wait_id | input | N_PART*IDW | Barrier number of each wait, field p at bits p*IDW +: IDW |
| release_o | output | N_PART | One-cycle release pulse per participant |
| err_o | output | N_PART | One-cycle duplicate-arrival error per participant |

## Verification
The stimulus covers four situations, and each one separates a different mechanism.
- All participants arrive on a single edge, which shows that simultaneous arrivals count together.
- Arrivals are staggered with one straggler, and a waiter is held until the straggler comes. This distinguishes a real hold from a premature release.
- A wait comes after completion or on the completing edge. This separates phase-based tracking from plain level sensing.
- A participant signals twice, and two barriers run concurrently with mixed numbers in the same cycle. This exposes double counting and crosstalk between barriers.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int SBU_PARTS = 8;
  localparam int SBU_BARS  = 4;

  function automatic int sbu_idw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sbu_rst_sync.sv
module sbu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/sbu_bar_slot.sv
module sbu_bar_slot #(
  parameter int N_PART = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PART-1:0] hit,
  output logic              phase_o,
  output logic [N_PART-1:0] tag_o,
  output logic [N_PART-1:0] dup_o,
  output logic [N_PART-1:0] arr_o
);
  logic [N_PART-1:0] arr_q, arr_d, acc, merged;
  logic [N_PART-1:0] tag_q, tag_d;
  logic              phase_q, phase_d, full, upd;

  always_comb begin
    acc     = hit & ~arr_q;
    merged  = arr_q | acc;
    full    = &merged;
    upd     = |hit;
    arr_d   = full ? '0 : merged;
    phase_d = phase_q ^ full;
    for (int p = 0; p < N_PART; p++) begin
      tag_d[p] = acc[p] ? phase_q : tag_q[p];
    end
    dup_o   = hit & arr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_q   <= '0;
      tag_q   <= '0;
      phase_q <= 1'b0;
    end else if (upd) begin
      arr_q   <= arr_d;
      tag_q   <= tag_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;
  assign tag_o   = tag_q;
  assign arr_o   = arr_q;
endmodule

// File: rtl/sbu_wait_slot.sv
module sbu_wait_slot #(
  parameter int N_BAR = 4,
  parameter int IDW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_req,
  input  logic [IDW-1:0]   wait_bar,
  input  logic [N_BAR-1:0] done_vec,
  output logic             release_o
);
  logic           pend_q, pend_d, rel, en;
  logic [IDW-1:0] bar_q, bar_d;

  always_comb begin
    rel    = pend_q & done_vec[bar_q];
    en     = wait_req | rel;
    pend_d = wait_req ? 1'b1 : 1'b0;
    bar_d  = wait_req ? wait_bar : bar_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      bar_q  <= '0;
    end else if (en) begin
      pend_q <= pend_d;
      bar_q  <= bar_d;
    end
  end

  assign release_o = rel;
endmodule

// File: rtl/split_barrier_unit.sv
module split_barrier_unit #(
  parameter int N_PART = sbu_pkg::SBU_PARTS,
  parameter int N_BAR  = sbu_pkg::SBU_BARS,
  localparam int IDW   = sbu_pkg::sbu_idw(N_BAR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_PART-1:0]     sig_valid,
  input  logic [N_PART*IDW-1:0] sig_id,
  input  logic [N_PART-1:0]     wait_valid,
  input  logic [N_PART*IDW-1:0] wait_id,
  output logic [N_PART-1:0]     release_o,
  output logic [N_PART-1:0]     err_o
);
  logic                    rst_sync_n;
  logic [N_BAR-1:0]        bar_phase;
  logic [N_BAR-1:0]        bar_hit_any;
  logic [N_BAR*N_PART-1:0] bar_arr;
  logic [N_BAR*N_PART-1:0] bar_tag;
  logic [N_BAR*N_PART-1:0] bar_dup;
  logic [N_BAR*N_PART-1:0] bar_hit;
  logic [N_PART-1:0]       dup_any;
  logic [N_PART-1:0]       err_q;

  sbu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  always_comb begin
    dup_any = '0;
    for (int b = 0; b < N_BAR; b++) begin
      for (int p = 0; p < N_PART; p++) begin
        bar_hit[b*N_PART+p] = sig_valid[p] && (sig_id[p*IDW +: IDW] == IDW'(b));
      end
      bar_hit_any[b] = |bar_hit[b*N_PART +: N_PART];
      dup_any        = dup_any | bar_dup[b*N_PART +: N_PART];
    end
  end

  for (genvar b = 0; b < N_BAR; b++) begin : g_bar
    sbu_bar_slot #(.N_PART(N_PART)) u_slot (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .hit     (bar_hit[b*N_PART +: N_PART]),
      .phase_o (bar_phase[b]),
      .tag_o   (bar_tag[b*N_PART +: N_PART]),
      .dup_o   (bar_dup[b*N_PART +: N_PART]),
      .arr_o   (bar_arr[b*N_PART +: N_PART])
    );
  end

  for (genvar p = 0; p < N_PART; p++) begin : g_part
    logic [N_BAR-1:0] done_vec;
    always_comb begin
      for (int b = 0; b < N_BAR; b++) begin
        done_vec[b] = bar_phase[b] ^ bar_tag[b*N_PART+p];
      end
    end
    sbu_wait_slot #(.N_BAR(N_BAR), .IDW(IDW)) u_wait (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wait_req  (wait_valid[p]),
      .wait_bar  (wait_id[p*IDW +: IDW]),
      .done_vec  (done_vec),
      .release_o (release_o[p])
    );
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= '0;
    else             err_q <= dup_any;
  end

  assign err_o = err_q;
endmodule

// File: rtl/sbu_chk.sv
module sbu_chk #(
  parameter int N_PART = 8,
  parameter int N_BAR  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_PART-1:0]       sig_valid,
  input logic [N_PART-1:0]       wait_valid,
  input logic [N_PART-1:0]       release_o,
  input logic [N_PART-1:0]       err_o,
  input logic [N_BAR-1:0]        phase,
  input logic [N_BAR-1:0]        hit_any,
  input logic [N_BAR*N_PART-1:0] arr
);
  for (genvar p = 0; p < N_PART; p++) begin : g_p
    // R8
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o[p] |-> $past(sig_valid[p]));
    // R4
    rel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (release_o[p] && !wait_valid[p]) |=> !release_o[p]);
  end

  for (genvar b = 0; b < N_BAR; b++) begin : g_b
    // R9
    phase_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase[b]) |-> $past(hit_any[b]));
    // R3
    clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase[b]) |-> (arr[b*N_PART +: N_PART] == '0));
  end
endmodule

bind split_barrier_unit sbu_chk #(.N_PART(N_PART), .N_BAR(N_BAR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .sig_valid  (sig_valid),
  .wait_valid (wait_valid),
  .release_o  (release_o),
  .err_o      (err_o),
  .phase      (bar_phase),
  .hit_any    (bar_hit_any),
  .arr        (bar_arr)
);

// File: tb/tb_split_barrier_unit.sv
module tb_split_barrier_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 8;
  localparam int NB  = 4;
  localparam int IDW = 2;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst_n;
  logic [NP-1:0]     sig_valid, wait_valid, release_o, err_o;
  logic [NP*IDW-1:0] sig_id, wait_id;
  logic [NP-1:0]     st_sv, st_wv;
  logic [NP*IDW-1:0] st_sid, st_wid;

  split_barrier_unit #(.N_PART(NP), .N_BAR(NB)) dut (
    .clk(clk), .rst_n(rst_n), .sig_valid(sig_valid), .sig_id(sig_id),
    .wait_valid(wait_valid), .wait_id(wait_id),
    .release_o(release_o), .err_o(err_o)
  );

  typedef struct {bit is_err; int part; int cyc; string req;} exp_t;
  exp_t sb[$];
  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic observe(input bit e, input int p);
    int idx = -1;
    foreach (sb[i]) if (idx < 0 && sb[i].is_err == e && sb[i].part == p && sb[i].cyc == cyc) idx = i;
    n_tests++;
    if (idx >= 0) sb.delete(idx);
    else begin
      n_fail++;
      $display("FAIL %s unexpected %s[%0d] at cycle %0d: actual 1 expected 0",
               e ? "R8" : "R4", e ? "err_o" : "release_o", p, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (run) begin
      for (int p = 0; p < NP; p++) begin
        if (release_o[p]) observe(1'b0, p);
        if (err_o[p])     observe(1'b1, p);
      end
      while (sb.size() > 0 && sb[0].cyc < cyc) begin
        n_tests++;
        n_fail++;
        $display("FAIL %s missing %s[%0d] at cycle %0d: actual 0 expected 1",
                 sb[0].req, sb[0].is_err ? "err_o" : "release_o", sb[0].part, sb[0].cyc);
        sb.delete(0);
      end
    end
  end

  task automatic put_sig(input int p, input int b);
    st_sv[p] = 1'b1;
    st_sid[p*IDW +: IDW] = b[IDW-1:0];
  endtask

  task automatic put_wait(input int p, input int b);
    st_wv[p] = 1'b1;
    st_wid[p*IDW +: IDW] = b[IDW-1:0];
  endtask

  task automatic tick();
    @(negedge clk);
    sig_valid = st_sv; sig_id = st_sid; wait_valid = st_wv; wait_id = st_wid;
    @(posedge clk);
    #1;
    sig_valid = '0; sig_id = '0; wait_valid = '0; wait_id = '0;
    st_sv = '0; st_sid = '0; st_wv = '0; st_wid = '0;
  endtask

  task automatic exp_ev(input bit e, input int p, input string r);
    sb.push_back('{e, p, cyc, r});
  endtask

  task automatic chk_quiet(input string r);
    @(negedge clk);
    n_tests++;
    if (release_o !== '0) begin
      n_fail++;
      $display("FAIL %s hold: release_o actual %b expected %b", r, release_o, {NP{1'b0}});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sig_valid = '0; sig_id = '0; wait_valid = '0; wait_id = '0;
    st_sv = '0; st_sid = '0; st_wv = '0; st_wid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    n_tests++;
    if (release_o !== '0) begin n_fail++; $display("FAIL R1 release_o actual %b expected 0", release_o); end
    n_tests++;
    if (err_o !== '0) begin n_fail++; $display("FAIL R1 err_o actual %b expected 0", err_o); end
    run = 1'b1;

    // R1: a wait before any arrival is held (p6 on barrier 2)
    put_wait(6, 2); tick();
    chk_quiet("R1");

    // R3/R5: everyone arrives on barrier 0 together, late waiter released at once
    for (int p = 0; p < NP; p++) put_sig(p, 0);
    tick();
    put_wait(3, 0); tick(); exp_ev(1'b0, 3, "R5");
    // R7: re-arrive in new phase, then wait -> held
    put_sig(3, 0); tick();
    put_wait(3, 0); tick();
    chk_quiet("R7");
    for (int p = 0; p < NP; p++) if (p != 3) put_sig(p, 0);
    tick(); exp_ev(1'b0, 3, "R7");

    // R2/R4/R6: barrier 1, staggered with straggler p7
    for (int p = 0; p < 7; p++) put_sig(p, 1);
    tick();
    put_wait(0, 1); tick();
    tick(); tick();
    chk_quiet("R4");
    put_sig(7, 1); put_wait(2, 1); tick();
    exp_ev(1'b0, 0, "R4");
    exp_ev(1'b0, 2, "R6");

    // R8: duplicate arrival on barrier 2
    put_sig(5, 2); tick();
    put_sig(5, 2); tick(); exp_ev(1'b1, 5, "R8");
    put_wait(5, 2); tick();
    for (int p = 0; p < 7; p++) if (p != 5) put_sig(p, 2);
    tick(); tick();
    chk_quiet("R8");
    put_sig(7, 2); tick();
    exp_ev(1'b0, 5, "R8");
    exp_ev(1'b0, 6, "R1");

    // R9: barriers 3 and 1 in flight together
    for (int p = 1; p < NP; p++) put_sig(p, 3);
    put_sig(0, 1);
    tick();
    put_wait(1, 3); tick();
    chk_quiet("R9");
    put_sig(0, 3); tick(); exp_ev(1'b0, 1, "R9");
    put_wait(0, 1); tick();
    chk_quiet("R9");
    tick(); tick(); tick();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule